// File: doc/BRIEF.md
# Static Memory Burst Write Sequencer

This block turns one write request from an internal bus master into a burst of two to four back-to-back write beats on an external asynchronous static memory bus. The request carries a start address, a halfword/word size flag and a beat count. The write data then arrives beat by beat over a valid/ready handshake. For each beat the block drives chip select, address, data, the size and direction indicators, and an optional active-low write-enable pulse. The output-enable line is held high throughout.

Each beat lasts one clock, plus a programmed number of wait states, plus one clock for every low sample of an external ready line. Ready is captured on the falling clock edge. When the write-enable strobe is in use, a programmed wait count of zero is raised to one, because a write pulse cannot be formed inside a single-clock beat. The bus address steps by 4 bytes for word beats and by 2 bytes for halfword beats. Address, data, size and direction keep their last values after the burst until the next burst drives new ones.

Top module: `sram_burst_writer`

## Requirements
- R1: While reset is asserted, and after it, busCsN, busWeN and busOeN are 1, burstDone is 0, busWrite is 0 and reqReady is 1. A reset in the middle of a burst returns the block to idle with these values.
- R2: A burst issues clamp(reqLen, 2, 4) beats. reqLen values 0 and 1 give 2 beats, and values 5 to 7 give 4 beats.
- R3: With ready held high, each beat lasts 1 + W clocks, where W is the effective wait count. With W = 0 and the write strobe disabled, a four-beat burst keeps busCsN low for exactly 4 clocks.
- R4: When cfgUseWe is 1 and cfgWait is 0, W is 1. Otherwise W equals cfgWait (0 to 15).
- R5: extRdy is sampled on the falling clock edge only in the clocks after a beat's wait states have run out. Each low sample there lengthens that beat by exactly one clock. A low level during the programmed wait clocks has no effect.
- R6: With cfgUseWe = 1, busWeN goes low at the start of each beat and stays low for exactly W clocks, then is high for the rest of the beat. This gives one pulse per beat. With cfgUseWe = 0, busWeN stays 1.
- R7: busCsN falls once when the first beat starts and stays low, including any data-wait gaps, until the last beat completes. busOeN is always 1.
- R8: Beat i of a burst drives busAddr = start + i*4 for word beats and start + i*2 for halfword beats. busHalf = reqHalf, busWord = !reqHalf and busWrite = 1.
- R9: After a burst ends, busAddr, busData, busHalf, busWord and busWrite hold their values from the last beat.
- R10: reqReady is 1 only while idle. beatReady is 1 only while waiting for a beat or in the completing clock of a beat that is not the last. Each beat drives the data word accepted for it, and a missing data word holds chip select low until the word arrives.
- R11: burstDone is a single-clock pulse in the first clock after the last beat, with busCsN already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Burst request valid |
| reqReady | output | 1 | Block idle, request accepted |
| reqAddr | input | 32 | Start byte address |
| reqHalf | input | 1 | 1 = halfword beats, 0 = word beats |
| reqLen | input | 3 | Requested beat count (clamped to 2..4) |
| cfgWait | input | 4 | Programmed wait states per beat |
| cfgUseWe | input | 1 | Write-enable strobe in use |
| beatValid | input | 1 | Write data word valid |
| beatReady | output | 1 | Write data word taken this clock |
| beatData | input | 32 | Write data word |
| extRdy | input | 1 | External ready, low to stretch a beat |
| busCsN | output | 1 | Chip select, active low |
| busAddr | output | 32 | Bus address |
| busData | output | 32 | Bus write data |
| busOeN | output | 1 | Output enable, held high |
| busWeN | output | 1 | Write-enable strobe, active low |
| busHalf | output | 1 | Halfword size indicator |
| busWord | output | 1 | Word size indicator |
| busWrite | output | 1 | Write direction indicator |
| burstDone | output | 1 | Burst complete pulse |

## Verification
The sharpest overlap is between the programmed wait countdown and the ready stall. A ready line that is low at the falling edge where the wait count has just reached zero must add a clock. The same low level one clock earlier, inside the wait states, must add nothing. The bench drives extRdy low for a chosen number of clocks from the first beat's start, both shorter and longer than the wait count. It then compares the total number of chip-select-low clocks with 1 + W per beat plus the excess low clocks. A second overlap, a beat completing in the same clock in which the next data word is missing, is provoked by withholding beatValid. It is judged by the chip-select width and by the address and data of every beat.

// File: rtl/sram_burst_writer_pkg.sv
`timescale 1ns/1ps
package sram_burst_writer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_BEAT  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic captureReq;
    logic loadBeat;
    logic firstBeat;
  } ctrlStb_t;

endpackage

// File: rtl/sram_burst_writer_ctrl.sv
`timescale 1ns/1ps
module sram_burst_writer_ctrl
  import sram_burst_writer_pkg::*;
#(
  parameter int LEN_W     = 3,
  parameter int WAIT_W    = 4,
  parameter int MIN_BEATS = 2,
  parameter int MAX_BEATS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgUseWe,
  input  logic              beatValid,
  output logic              beatReady,
  input  logic              extRdy,
  output ctrlStb_t          stb,
  output logic              csN,
  output logic              weN,
  output logic              done
);

  localparam logic [LEN_W-1:0]  LEN_LO   = LEN_W'(MIN_BEATS);
  localparam logic [LEN_W-1:0]  LEN_HI   = LEN_W'(MAX_BEATS);
  localparam logic [WAIT_W-1:0] WAIT_ONE = WAIT_W'(1);

  seqState_t         state;
  logic [LEN_W-1:0]  beatsLeft;
  logic [LEN_W-1:0]  lenClamp;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitLat;
  logic [WAIT_W-1:0] effWait;
  logic              useWeLat;
  logic              rdySamp;
  logic              capture;
  logic              beatDone;
  logic              lastBeat;
  logic              loadBeat;

  // ready captured on the falling edge, used at the following rising edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) rdySamp <= 1'b0;
    else       rdySamp <= extRdy;
  end

  always_comb begin
    if (reqLen < LEN_LO)      lenClamp = LEN_LO;
    else if (reqLen > LEN_HI) lenClamp = LEN_HI;
    else                      lenClamp = reqLen;
  end

  // a strobe-based write needs at least one wait clock to form a pulse
  assign effWait   = (cfgUseWe && (cfgWait == '0)) ? WAIT_ONE : cfgWait;

  assign reqReady  = (state == ST_IDLE);
  assign capture   = reqValid && reqReady;
  assign beatDone  = (state == ST_BEAT) && (waitCnt == '0) && rdySamp;
  assign lastBeat  = (beatsLeft == LEN_W'(1));
  assign beatReady = (state == ST_FETCH) || (beatDone && !lastBeat);
  assign loadBeat  = beatReady && beatValid;

  assign stb.captureReq = capture;
  assign stb.loadBeat   = loadBeat;
  assign stb.firstBeat  = (state == ST_FETCH) && csN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      beatsLeft <= '0;
      waitCnt   <= '0;
      waitLat   <= '0;
      useWeLat  <= 1'b0;
      csN       <= 1'b1;
      weN       <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (capture) begin
            state     <= ST_FETCH;
            beatsLeft <= lenClamp;
            waitLat   <= effWait;
            useWeLat  <= cfgUseWe;
          end
        end
        ST_FETCH: begin
          if (loadBeat) begin
            state   <= ST_BEAT;
            csN     <= 1'b0;
            waitCnt <= waitLat;
            weN     <= ~useWeLat;
          end
        end
        ST_BEAT: begin
          if (waitCnt != '0) begin
            waitCnt <= waitCnt - WAIT_ONE;
            if (waitCnt == WAIT_ONE) weN <= 1'b1;
          end else if (rdySamp) begin
            beatsLeft <= beatsLeft - LEN_W'(1);
            if (lastBeat) begin
              state <= ST_IDLE;
              csN   <= 1'b1;
              weN   <= 1'b1;
              done  <= 1'b1;
            end else if (loadBeat) begin
              waitCnt <= waitLat;
              weN     <= ~useWeLat;
            end else begin
              state <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !csN);  // R6
  AST_WE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BEAT && waitCnt == '0) |-> weN);  // R6
  AST_FORCED_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (loadBeat && useWeLat) |=> (waitCnt != '0));  // R4
  AST_RDY_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BEAT && waitCnt == '0 && !rdySamp) |=>
      (state == ST_BEAT && !csN && $stable(beatsLeft)));  // R5
  AST_BEATS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (beatsLeft >= LEN_W'(1) && beatsLeft <= LEN_HI));  // R2
  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |-> csN);  // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R11
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && $past(!csN)));  // R11

endmodule

// File: rtl/sram_burst_writer_dpath.sv
`timescale 1ns/1ps
module sram_burst_writer_dpath
  import sram_burst_writer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqHalf,
  input  logic [DATA_W-1:0] beatData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic              busHalf,
  output logic              busWord,
  output logic              busWrite
);

  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(DATA_W / 8);
  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(DATA_W / 16);

  logic [ADDR_W-1:0] addrNext;
  logic [ADDR_W-1:0] step;
  logic              halfLat;

  assign step = halfLat ? STEP_HALF : STEP_WORD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrNext <= '0;
      halfLat  <= 1'b0;
    end else if (stb.captureReq) begin
      addrNext <= reqAddr;
      halfLat  <= reqHalf;
    end else if (stb.loadBeat) begin
      addrNext <= addrNext + step;
    end
  end

  // bus-side registers only change when a beat is launched
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr  <= '0;
      busData  <= '0;
      busHalf  <= 1'b0;
      busWord  <= 1'b0;
      busWrite <= 1'b0;
    end else if (stb.loadBeat) begin
      busAddr  <= addrNext;
      busData  <= beatData;
      busHalf  <= halfLat;
      busWord  <= ~halfLat;
      busWrite <= 1'b1;
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadBeat && !stb.firstBeat) |=> (busAddr == $past(busAddr) + $past(step)));  // R8
  AST_SIZE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadBeat |=> (busHalf != busWord && busWrite));  // R8
  AST_FIRST_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadBeat && stb.firstBeat) |=> (busAddr == $past(addrNext)));  // R8

endmodule

// File: rtl/sram_burst_writer.sv
`timescale 1ns/1ps
module sram_burst_writer
  import sram_burst_writer_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 3,
  parameter int WAIT_W    = 4,
  parameter int MIN_BEATS = 2,
  parameter int MAX_BEATS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqHalf,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [WAIT_W-1:0] cfgWait,
  input  logic              cfgUseWe,
  input  logic              beatValid,
  output logic              beatReady,
  input  logic [DATA_W-1:0] beatData,
  input  logic              extRdy,
  output logic              busCsN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData,
  output logic              busOeN,
  output logic              busWeN,
  output logic              busHalf,
  output logic              busWord,
  output logic              busWrite,
  output logic              burstDone
);

  ctrlStb_t stb;

  sram_burst_writer_ctrl #(
    .LEN_W(LEN_W), .WAIT_W(WAIT_W), .MIN_BEATS(MIN_BEATS), .MAX_BEATS(MAX_BEATS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqLen(reqLen),
    .cfgWait(cfgWait), .cfgUseWe(cfgUseWe),
    .beatValid(beatValid), .beatReady(beatReady), .extRdy(extRdy),
    .stb(stb), .csN(busCsN), .weN(busWeN), .done(burstDone)
  );

  sram_burst_writer_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqAddr(reqAddr), .reqHalf(reqHalf), .beatData(beatData),
    .busAddr(busAddr), .busData(busData),
    .busHalf(busHalf), .busWord(busWord), .busWrite(busWrite)
  );

  // writes only: the read strobe is never driven active
  assign busOeN = 1'b1;

endmodule

// File: tb/sram_burst_writer_bench.sv
`timescale 1ns/1ps
module sram_burst_writer_bench;

  localparam int NV = 10;
  localparam logic [31:0] DBASE = 32'hA500_0000;
  localparam int V_LEN  [NV] = '{4, 2, 3, 4, 1, 7, 2, 2, 3, 3};
  localparam int V_HALF [NV] = '{0, 1, 0, 1, 0, 0, 0, 1, 0, 0};
  localparam int V_WAIT [NV] = '{0, 0, 2, 0, 1, 0, 2, 1, 15, 0};
  localparam int V_WE   [NV] = '{0, 0, 1, 1, 0, 0, 1, 1, 0, 0};
  localparam int V_RDY  [NV] = '{0, 0, 0, 0, 0, 3, 2, 4, 0, 0};
  localparam int V_GAP  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 3};
  localparam int V_ADDR [NV] = '{'h1000, 'h2002, 'h3000, 'h4000, 'h5000,
                                 'h6000, 'h7000, 'h8000, 'h9000, 'hA000};
  localparam int E_BEATS[NV] = '{4, 2, 3, 4, 2, 4, 2, 2, 3, 3};
  localparam int E_CS   [NV] = '{4, 2, 9, 8, 4, 7, 6, 7, 48, 6};
  localparam int E_WEL  [NV] = '{0, 0, 6, 4, 0, 0, 4, 2, 0, 0};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqHalf = 1'b0;
  logic [2:0]  reqLen = '0;
  logic [3:0]  cfgWait = '0;
  logic        cfgUseWe = 1'b0;
  logic        beatValid = 1'b0;
  logic        beatReady;
  logic [31:0] beatData = DBASE;
  logic        extRdy = 1'b1;
  logic        busCsN, busOeN, busWeN, busHalf, busWord, busWrite, burstDone;
  logic [31:0] busAddr, busData;

  int nChecks = 0;
  int nFail = 0;
  int hsCount = 0;

  always #2.5 clk = ~clk;

  sram_burst_writer u_sram_burst_writer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqHalf(reqHalf), .reqLen(reqLen), .cfgWait(cfgWait),
    .cfgUseWe(cfgUseWe), .beatValid(beatValid), .beatReady(beatReady),
    .beatData(beatData), .extRdy(extRdy), .busCsN(busCsN), .busAddr(busAddr),
    .busData(busData), .busOeN(busOeN), .busWeN(busWeN), .busHalf(busHalf),
    .busWord(busWord), .busWrite(busWrite), .burstDone(burstDone)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idleChecks(input string req);
    chk(busCsN == 1'b1, req, "csN idle", busCsN, 1);
    chk(busWeN == 1'b1, req, "weN idle", busWeN, 1);
    chk(busOeN == 1'b1, req, "oeN idle", busOeN, 1);
    chk(burstDone == 1'b0, req, "done idle", burstDone, 0);
    chk(reqReady == 1'b1, req, "reqReady idle", reqReady, 1);
  endtask

  task automatic runBurst(input int v);
    int startIdx = hsCount;
    int step = V_HALF[v] ? 2 : 4;
    int cyc = 0, beatNo = 0, csLow = 0, weLow = 0, weFalls = 0, csFalls = 0;
    int sinceLoad = -1, hsInBurst = 0;
    bit prevCs = 1'b1, prevWe = 1'b1, hsPend = 1'b0, reqAcc = 1'b0, doneSeen = 1'b0;
    logic [31:0] prevAddr = '0;
    string lenTag;
    if (V_RDY[v] > 0)                          lenTag = "R5";
    else if (V_GAP[v] > 0)                     lenTag = "R10";
    else if (V_WE[v] == 1 && V_WAIT[v] == 0)   lenTag = "R4";
    else                                       lenTag = "R3";
    @(posedge clk); #1;
    reqValid = 1'b1; reqAddr = V_ADDR[v]; reqHalf = V_HALF[v][0];
    reqLen = V_LEN[v][2:0]; cfgWait = V_WAIT[v][3:0]; cfgUseWe = V_WE[v][0];
    extRdy = (V_RDY[v] > 0) ? 1'b0 : 1'b1; beatValid = 1'b1;
    while (!doneSeen && cyc < 400) begin
      #3;
      if (!busCsN) csLow++;
      if (!busWeN) weLow++;
      if (prevWe && !busWeN) weFalls++;
      if (prevCs && !busCsN) csFalls++;
      if (!busCsN && (prevCs || busAddr != prevAddr)) begin
        chk(busAddr == 32'(V_ADDR[v] + beatNo * step), "R8", "beat address",
            busAddr, V_ADDR[v] + beatNo * step);
        chk(busData == DBASE + 32'(startIdx + beatNo), "R10", "beat data",
            busData, DBASE + 32'(startIdx + beatNo));
        chk(busHalf == V_HALF[v][0] && busWord == !V_HALF[v][0], "R8", "size flags",
            {busHalf, busWord}, {V_HALF[v][0], !V_HALF[v][0]});
        chk(busWrite == 1'b1, "R8", "write flag", busWrite, 1);
        chk(busOeN == 1'b1, "R7", "oeN in burst", busOeN, 1);
        beatNo++;
      end
      if (burstDone) begin
        doneSeen = 1'b1;
        chk(busCsN == 1'b1 && !prevCs, "R11", "done timing", {busCsN, prevCs}, 2'b10);
      end
      hsPend = beatReady && beatValid;
      reqAcc = reqValid && reqReady;
      prevCs = busCsN; prevWe = busWeN; prevAddr = busAddr;
      @(posedge clk); #1;
      cyc++;
      if (reqAcc) reqValid = 1'b0;
      if (sinceLoad >= 0) sinceLoad++;
      if (hsPend) begin
        hsCount++; hsInBurst++;
        beatData = DBASE + 32'(hsCount);
        if (hsInBurst == 1) sinceLoad = 0;
      end
      extRdy = (V_RDY[v] > 0 && (sinceLoad < 0 || sinceLoad < V_RDY[v])) ? 1'b0 : 1'b1;
      beatValid = (V_GAP[v] > 0 && sinceLoad >= 0 && sinceLoad < V_GAP[v]) ? 1'b0 : 1'b1;
    end
    chk(doneSeen, "R11", "done seen", doneSeen, 1);
    chk(beatNo == E_BEATS[v], "R2", "beat count", beatNo, E_BEATS[v]);
    chk(csLow == E_CS[v], lenTag, "chip select clocks", csLow, E_CS[v]);
    chk(weLow == E_WEL[v], "R6", "strobe low clocks", weLow, E_WEL[v]);
    chk(weFalls == (V_WE[v] ? E_BEATS[v] : 0), "R6", "strobe pulses", weFalls,
        V_WE[v] ? E_BEATS[v] : 0);
    chk(csFalls == 1, "R7", "chip select falls", csFalls, 1);
    repeat (3) @(posedge clk);
    #4;
    chk(busAddr == 32'(V_ADDR[v] + (E_BEATS[v] - 1) * step), "R9", "address hold",
        busAddr, V_ADDR[v] + (E_BEATS[v] - 1) * step);
    chk(busData == DBASE + 32'(startIdx + E_BEATS[v] - 1), "R9", "data hold",
        busData, DBASE + 32'(startIdx + E_BEATS[v] - 1));
    chk(busWrite == 1'b1 && busHalf == V_HALF[v][0], "R9", "flag hold",
        {busWrite, busHalf}, {1'b1, V_HALF[v][0]});
    chk(beatReady == 1'b0 && reqReady == 1'b1, "R10", "idle handshake",
        {beatReady, reqReady}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #4;
    idleChecks("R1");
    chk(busWrite == 1'b0, "R1", "write flag reset", busWrite, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(posedge clk); #3;
    idleChecks("R1");

    for (int v = 0; v < NV; v++) runBurst(v);

    // reset in the middle of a long burst
    @(posedge clk); #1;
    reqValid = 1'b1; reqAddr = 32'hB000; reqLen = 3'd4; cfgWait = 4'd15;
    cfgUseWe = 1'b1; beatValid = 1'b1; extRdy = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    repeat (4) @(posedge clk);
    #4;
    chk(busCsN == 1'b0 && busWeN == 1'b0, "R6", "strobe active mid burst",
        {busCsN, busWeN}, 2'b00);
    @(posedge clk); #1;
    rstN = 1'b0;
    #3;
    idleChecks("R1");
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #4;
    idleChecks("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule